// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two processor-facing requests. One is a normal interrupt and the other is a critical (machine-check) interrupt. Each line is conditioned on its own terms:
- a polarity setting picks whether the line is active high or active low;
- a trigger setting picks edge or level sensing;
- a routing setting sends the line to one of the two outputs.

Pending state is kept in a status register. Software acknowledges a source by writing a one to that source's status bit. Writing zero bits leaves the other sources untouched.

Software reaches the block through a small word-addressed register port. The write is synchronous and the read is combinational. Besides the raw pending bits, software can read the pending bits gated by the enables. It can also read the number of the most urgent enabled pending source, with a valid flag. A one-bit ordering setting selects whether source 0 or source 31 is the most urgent. Request inputs are asynchronous and pass through a two-stage synchroniser. Both outputs are registered.

Top module: `intc_unit`

## Requirements
- R1: After reset, every readable word reads zero and both request outputs are low. This assumes the request inputs are held high. The word addresses are:
  - 0: pending (write one to clear)
  - 1: enable
  - 2: routing
  - 3: polarity
  - 4: trigger
  - 5: ordering (bit 0)
  - 6: enabled-pending (read only)
  - 7: top-source (read only)
- R2: Source n uses bit (31 − n) of every 32-bit word and of the `irq_in` port, so source 0 is the most significant bit.
- R3: A polarity bit of 0 treats the line as active low, and a bit of 1 treats it as active high.
- R4: With trigger bit 1, the source becomes pending on the inactive-to-active transition of its synchronised line. It stays pending after the line returns to inactive, until it is acknowledged.
- R5: With trigger bit 0, the pending bit follows the conditioned line. Writing a one to clear it has no lasting effect while the line stays active.
- R6: Writing a one to a pending bit clears an edge-latched source on the next clock edge. Zero bits in the same write leave their sources pending.
- R7: The enabled-pending word equals pending AND enable. A disabled source still latches pending but drives no output.
- R8: A source with routing bit 1 drives the normal output, and one with routing bit 0 drives the critical output. Each output is the registered OR of its enabled pending sources and is low when nothing enabled is pending.
- R9: The top-source word carries the winning source number in bits 4:0 and a valid flag in bit 31. The word is all zero when no enabled source is pending.
- R10: With ordering bit 1, the lowest-numbered enabled pending source wins. With ordering bit 0, the highest-numbered one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Asynchronous request lines, source n on bit 31−n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
A held active-low level on one source shows that level status follows the line and cannot be acknowledged away. It also shows that routing moves the request between the two outputs. A short low pulse on an edge-mode source shows latching after the line returns inactive. It is followed by acknowledges with and without the matching bit set, which separate a targeted clear from a blanket one. A disabled edge source separates the raw pending view from the enabled view and the outputs. Three enabled sources pending at once, read under both ordering settings, tell the two priority directions apart. An active-high source whose input sits high shows the polarity inversion.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [2:0] {
        REG_PEND   = 3'd0,
        REG_ENA    = 3'd1,
        REG_ROUTE  = 3'd2,
        REG_POL    = 3'd3,
        REG_TRIG   = 3'd4,
        REG_ORDER  = 3'd5,
        REG_MPEND  = 3'd6,
        REG_TOPSRC = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned      WIDTH   = 32,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/intc_src_cell.sv
module intc_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sync,
    input  logic pol_high,
    input  logic edge_mode,
    input  logic ack,
    output logic pend
);
    logic active;
    logic prev_q;
    logic pend_q;
    logic rise;

    // polarity conditioning: 1 = active high, 0 = active low
    assign active = pol_high ? line_sync : ~line_sync;
    assign rise   = active & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= active;
            if (edge_mode) begin
                pend_q <= rise | (pend_q & ~ack);
            end else begin
                pend_q <= active;
            end
        end
    end

    assign pend = pend_q;

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !rise) |=> !pend_q); // R6
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pend_q && !ack) |=> pend_q); // R4
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && active) |=> pend_q); // R5
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               low_first,
    output logic               valid,
    output logic [ID_W-1:0]    src_id
);
    always_comb begin
        valid  = 1'b0;
        src_id = '0;
        if (low_first) begin
            // walk downward so the smallest source number is written last
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (req[NUM_SRC-1-i]) begin
                    valid  = 1'b1;
                    src_id = ID_W'(i);
                end
            end
        end else begin
            // walk upward so the largest source number is written last
            for (int i = 0; i < NUM_SRC; i++) begin
                if (req[NUM_SRC-1-i]) begin
                    valid  = 1'b1;
                    src_id = ID_W'(i);
                end
            end
        end
    end

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[NUM_SRC-1-int'(src_id)]); // R9
endmodule

// File: rtl/intc_unit.sv
module intc_unit #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_norm_o,
    output logic               irq_crit_o
);
    import intc_pkg::*;

    localparam int unsigned ID_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] ena_q;
    logic [NUM_SRC-1:0] route_q;
    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] trig_q;
    logic               order_q;
    logic [NUM_SRC-1:0] line_sync;
    logic [NUM_SRC-1:0] ack_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] masked;
    logic               top_valid;
    logic [ID_W-1:0]    top_id;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(reg_addr);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q   <= '0;
            route_q <= '0;
            pol_q   <= '0;
            trig_q  <= '0;
            order_q <= 1'b0;
        end else if (reg_we) begin
            unique case (sel)
                REG_ENA:   ena_q   <= reg_wdata;
                REG_ROUTE: route_q <= reg_wdata;
                REG_POL:   pol_q   <= reg_wdata;
                REG_TRIG:  trig_q  <= reg_wdata;
                REG_ORDER: order_q <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    // write-one-to-clear strobes for the pending word
    assign ack_vec = (reg_we && sel == REG_PEND) ? reg_wdata : '0;

    intc_sync #(.WIDTH(NUM_SRC), .RST_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (line_sync)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        intc_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_sync (line_sync[g]),
            .pol_high  (pol_q[g]),
            .edge_mode (trig_q[g]),
            .ack       (ack_vec[g]),
            .pend      (pend_vec[g])
        );
    end

    assign masked = pend_vec & ena_q;

    intc_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (masked),
        .low_first (order_q),
        .valid     (top_valid),
        .src_id    (top_id)
    );

    // registered request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_norm_o <= 1'b0;
            irq_crit_o <= 1'b0;
        end else begin
            irq_norm_o <= |(masked & route_q);
            irq_crit_o <= |(masked & ~route_q);
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_PEND:   reg_rdata = pend_vec;
            REG_ENA:    reg_rdata = ena_q;
            REG_ROUTE:  reg_rdata = route_q;
            REG_POL:    reg_rdata = pol_q;
            REG_TRIG:   reg_rdata = trig_q;
            REG_ORDER:  reg_rdata[0] = order_q;
            REG_MPEND:  reg_rdata = masked;
            REG_TOPSRC: begin
                reg_rdata[NUM_SRC-1] = top_valid;
                reg_rdata[ID_W-1:0]  = top_id;
            end
            default:    reg_rdata = '0;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |=> (!irq_norm_o && !irq_crit_o)); // R8
endmodule

// File: tb/intc_unit_tb.sv
`timescale 1ns/100ps
module intc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_norm_o;
    logic        irq_crit_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    intc_unit #(.NUM_SRC(32)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_norm_o (irq_norm_o),
        .irq_crit_o (irq_crit_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic out_check(input string tag, input logic n, input logic c);
        check({tag, " norm"}, {31'b0, irq_norm_o}, {31'b0, n});
        check({tag, " crit"}, {31'b0, irq_crit_o}, {31'b0, c});
    endtask

    task automatic pulse_low(input int bitpos);
        @(negedge clk);
        irq_in[bitpos] = 1'b0;
        idle(2);
        irq_in[bitpos] = 1'b1;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_check("R1 reset word", 3'(a), 32'h0);
        out_check("R1 reset outputs", 1'b0, 1'b0);
    endtask

    // source 3 -> bit 28, level, active low
    task automatic t_level;
        @(negedge clk); irq_in[28] = 1'b0;
        idle(5);
        rd_check("R2 R5 level pending bit 28", 3'd0, 32'h1000_0000);
        rd_check("R7 disabled masked view", 3'd6, 32'h0);
        wr(3'd1, 32'h1000_0000);
        idle(2);
        out_check("R8 route 0 to critical", 1'b0, 1'b1);
        rd_check("R9 top source 3", 3'd7, 32'h8000_0003);
        wr(3'd0, 32'h1000_0000);
        idle(2);
        rd_check("R5 level ack no effect", 3'd0, 32'h1000_0000);
        wr(3'd2, 32'h1000_0000);
        idle(2);
        out_check("R8 route 1 to normal", 1'b1, 1'b0);
        @(negedge clk); irq_in[28] = 1'b1;
        idle(5);
        rd_check("R5 level release", 3'd0, 32'h0);
        rd_check("R9 top source empty", 3'd7, 32'h0);
        out_check("R8 idle outputs", 1'b0, 1'b0);
    endtask

    // source 5 -> bit 26, edge
    task automatic t_edge;
        wr(3'd4, 32'h0400_0000);
        pulse_low(26);
        idle(5);
        rd_check("R4 edge latched after pulse", 3'd0, 32'h0400_0000);
        wr(3'd1, 32'h1400_0000);
        idle(2);
        out_check("R8 edge source critical", 1'b0, 1'b1);
        wr(3'd0, 32'h0000_0001);
        idle(1);
        rd_check("R6 other-bit ack keeps pending", 3'd0, 32'h0400_0000);
        wr(3'd0, 32'h0400_0000);
        rd_check("R6 ack clears", 3'd0, 32'h0);
        idle(2);
        out_check("R6 outputs after ack", 1'b0, 1'b0);
    endtask

    // source 7 -> bit 24, edge, not enabled
    task automatic t_mask;
        wr(3'd4, 32'h0500_0000);
        pulse_low(24);
        idle(5);
        rd_check("R7 disabled still pending", 3'd0, 32'h0100_0000);
        rd_check("R7 masked view excludes", 3'd6, 32'h0);
        out_check("R7 disabled no output", 1'b0, 1'b0);
    endtask

    task automatic t_prio;
        pulse_low(26);
        @(negedge clk); irq_in[28] = 1'b0;
        idle(5);
        rd_check("R7 masked view two", 3'd6, 32'h1400_0000);
        wr(3'd5, 32'h1);
        rd_check("R10 low-first picks 3", 3'd7, 32'h8000_0003);
        wr(3'd5, 32'h0);
        rd_check("R10 high-first picks 5", 3'd7, 32'h8000_0005);
        wr(3'd1, 32'h1500_0000);
        rd_check("R10 high-first picks 7", 3'd7, 32'h8000_0007);
        wr(3'd5, 32'h1);
        rd_check("R10 low-first still 3", 3'd7, 32'h8000_0003);
        idle(2);
        out_check("R8 both outputs", 1'b1, 1'b1);
        @(negedge clk); irq_in[28] = 1'b1;
        wr(3'd0, 32'h0500_0000);
        wr(3'd1, 32'h0);
        idle(5);
        rd_check("R6 cleanup pending", 3'd0, 32'h0);
    endtask

    // source 10 -> bit 21, active high
    task automatic t_pol;
        wr(3'd3, 32'h0020_0000);
        idle(5);
        rd_check("R3 active high pending", 3'd0, 32'h0020_0000);
        @(negedge clk); irq_in[21] = 1'b0;
        idle(5);
        rd_check("R3 active high released", 3'd0, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_level();
        t_edge();
        t_mask();
        t_prio();
        t_pol();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule